// File: doc/BRIEF.md
# Prefixed Opcode Predecoder

This block watches an instruction byte stream, one byte per strobed clock, and classifies each opcode before execution begins. For the accumulator-type arithmetic and logic group it reports the addressing mode and the operation nibble. For the single-bit clear group it reports the bit number. For every opcode it gives the number of operand bytes that follow and the number of execution cycles. Operand bytes are counted off and never decoded as opcodes.

A dedicated prefix byte (default 0x9E) arms a one-shot state that turns the two offset-indexed forms into stack-pointer-relative forms, which have their own lengths and cycle costs. The prefix itself produces no decode. Any opcode that the tables do not cover, including a prefix followed by an unsupported high nibble, is reported with an illegal flag and zero operand bytes, so the stream stays aligned.

Top module: `opc_predecode`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears dec_vld, the prefix state and the operand skip count. The first strobed byte after reset is treated as an opcode, and an armed prefix does not survive reset.
- R2: dec_vld is high for exactly one clock, in the cycle after the edge that samples a strobed opcode byte. It is never high in any other cycle.
- R3: Without a prefix, high nibbles 0xA, 0xB, 0xC, 0xD, 0xE and 0xF give mode codes 0 (immediate), 1 (direct), 2 (extended), 3 (16-bit indexed offset), 4 (8-bit indexed offset) and 5 (indexed, no offset). dec_op carries the opcode's low nibble.
- R4: The operand byte counts for mode codes 0 to 5 are 1, 1, 2, 2, 1 and 0.
- R5: The cycle counts for mode codes 0 to 5 are 2, 3, 4, 4, 3 and 2.
- R6: A strobed prefix byte gives no decode and arms the prefix. The next opcode with high nibble 0xE then reports mode 6 (8-bit stack offset), 1 operand byte and 4 cycles. With high nibble 0xD it reports mode 7 (16-bit stack offset), 2 operand bytes and 5 cycles.
- R7: An armed prefix followed by an opcode whose high nibble is neither 0xE nor 0xD (including a second prefix byte) gives dec_illegal=1, mode 0, 0 operand bytes and 1 cycle. It also disarms the prefix.
- R8: Opcodes 0x11, 0x13, ..., 0x1F give dec_bclr=1, dec_bit=(opcode-0x11)/2, mode 1, 1 operand byte and 4 cycles.
- R9: Every other unprefixed opcode (high nibble 0, 2 to 9 other than the prefix, and even values 0x10 to 0x1E) gives dec_illegal=1, mode 0, 0 operand bytes, 1 cycle and dec_bclr=0.
- R10: The dec_len strobed bytes that follow a decode are operands. They produce no decode and do not arm the prefix, whatever their value.
- R11: Cycles with byte_vld low change nothing. Gaps of any length may sit between an opcode and its operands, or between a prefix and its opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | Byte strobe |
| byte_in | input | 8 | Instruction stream byte |
| dec_vld | output | 1 | One-cycle decode pulse |
| dec_mode | output | 3 | Addressing mode code |
| dec_op | output | 4 | Opcode low nibble |
| dec_len | output | 2 | Operand bytes following the opcode |
| dec_cyc | output | 3 | Execution cycle count |
| dec_bclr | output | 1 | Bit-clear opcode |
| dec_bit | output | 3 | Bit number for bit-clear |
| dec_illegal | output | 1 | Unsupported opcode |

## Verification
A wrong skip count shifts opcode alignment. Within a few bytes this shows up as decodes where operands sit, or as missing decodes on real opcodes. A prefix flag that sticks or gets lost shows on the next 0xD_/0xE_ opcode as the wrong mode, length and cycle count. Since every later decode depends on alignment, the bench follows a long random stream with gaps, embedded prefix values and illegal bytes, and compares every cycle against a reference model.

// File: rtl/opc_pdec_pkg.sv
package opc_pdec_pkg;
   localparam int LEN_W = 2;
   localparam int CYC_W = 3;
   localparam int BIT_W = 3;

   typedef enum logic [2:0] {
      AM_IMM = 3'd0,
      AM_DIR = 3'd1,
      AM_EXT = 3'd2,
      AM_IX2 = 3'd3,
      AM_IX1 = 3'd4,
      AM_IX0 = 3'd5,
      AM_SP1 = 3'd6,
      AM_SP2 = 3'd7
   } amode_e;

   typedef struct packed {
      logic             illegal;
      logic             bclr;
      logic [BIT_W-1:0] bitn;
      amode_e           mode;
      logic [3:0]       op;
      logic [LEN_W-1:0] len;
      logic [CYC_W-1:0] cyc;
   } dec_t;
endpackage

// File: rtl/opc_pdec_table.sv
module opc_pdec_table
   import opc_pdec_pkg::*;
#(
   parameter int         BYTE_W   = 8,
   parameter logic [7:0] PFX_CODE = 8'h9E,
   parameter bit         SP_EN    = 1'b1
) (
   input  logic [BYTE_W-1:0] op_byte,
   input  logic              pfx_armed,
   output logic              is_prefix,
   output dec_t              dec
);
   localparam int NIB_W = BYTE_W / 2;

   logic [NIB_W-1:0] hi_nib;
   logic [NIB_W-1:0] lo_nib;
   dec_t             plain_dec;
   dec_t             sp_dec;
   dec_t             bad_dec;

   assign hi_nib = op_byte[BYTE_W-1:NIB_W];
   assign lo_nib = op_byte[NIB_W-1:0];

   always_comb begin
      bad_dec         = '0;
      bad_dec.illegal = 1'b1;
      bad_dec.mode    = AM_IMM;
      bad_dec.op      = lo_nib;
      bad_dec.cyc     = CYC_W'(1);
   end

   always_comb begin
      plain_dec      = '0;
      plain_dec.op   = lo_nib;
      plain_dec.mode = AM_IMM;
      unique case (hi_nib)
         4'hA: begin plain_dec.mode = AM_IMM; plain_dec.len = 2'd1; plain_dec.cyc = 3'd2; end
         4'hB: begin plain_dec.mode = AM_DIR; plain_dec.len = 2'd1; plain_dec.cyc = 3'd3; end
         4'hC: begin plain_dec.mode = AM_EXT; plain_dec.len = 2'd2; plain_dec.cyc = 3'd4; end
         4'hD: begin plain_dec.mode = AM_IX2; plain_dec.len = 2'd2; plain_dec.cyc = 3'd4; end
         4'hE: begin plain_dec.mode = AM_IX1; plain_dec.len = 2'd1; plain_dec.cyc = 3'd3; end
         4'hF: begin plain_dec.mode = AM_IX0; plain_dec.len = 2'd0; plain_dec.cyc = 3'd2; end
         4'h1: begin
            if (lo_nib[0]) begin
               plain_dec.bclr = 1'b1;
               plain_dec.bitn = lo_nib[3:1];
               plain_dec.mode = AM_DIR;
               plain_dec.len  = 2'd1;
               plain_dec.cyc  = 3'd4;
            end else begin
               plain_dec = bad_dec;
            end
         end
         default: plain_dec = bad_dec;
      endcase
   end

   generate
      if (SP_EN) begin : g_sp
         assign is_prefix = (op_byte == PFX_CODE);
         always_comb begin
            sp_dec    = bad_dec;
            if (hi_nib == 4'hE) begin
               sp_dec         = '0;
               sp_dec.op      = lo_nib;
               sp_dec.mode    = AM_SP1;
               sp_dec.len     = 2'd1;
               sp_dec.cyc     = 3'd4;
            end else if (hi_nib == 4'hD) begin
               sp_dec         = '0;
               sp_dec.op      = lo_nib;
               sp_dec.mode    = AM_SP2;
               sp_dec.len     = 2'd2;
               sp_dec.cyc     = 3'd5;
            end
         end
         assign dec = pfx_armed ? sp_dec : plain_dec;
      end else begin : g_nosp
         assign is_prefix = 1'b0;
         assign sp_dec    = bad_dec;
         assign dec       = plain_dec;
      end
   endgenerate
endmodule

// File: rtl/opc_pdec_seq.sv
module opc_pdec_seq
   import opc_pdec_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_vld,
   input  logic             is_prefix,
   input  logic [LEN_W-1:0] new_len,
   output logic             take,
   output logic             pfx_q,
   output logic [LEN_W-1:0] skip_q
);
   logic skipping;
   logic arming;

   assign skipping = (skip_q != '0);
   assign arming   = byte_vld && !skipping && !pfx_q && is_prefix;
   assign take     = byte_vld && !skipping && !arming;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pfx_q  <= 1'b0;
         skip_q <= '0;
      end else if (byte_vld) begin
         if (skipping) begin
            skip_q <= skip_q - 1'b1;
         end else if (arming) begin
            pfx_q  <= 1'b1;
         end else begin
            pfx_q  <= 1'b0;
            skip_q <= new_len;
         end
      end
   end
endmodule

// File: rtl/opc_predecode.sv
module opc_predecode
   import opc_pdec_pkg::*;
#(
   parameter int         BYTE_W   = 8,
   parameter logic [7:0] PFX_CODE = 8'h9E,
   parameter bit         SP_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_in,
   output logic              dec_vld,
   output logic [2:0]        dec_mode,
   output logic [3:0]        dec_op,
   output logic [LEN_W-1:0]  dec_len,
   output logic [CYC_W-1:0]  dec_cyc,
   output logic              dec_bclr,
   output logic [BIT_W-1:0]  dec_bit,
   output logic              dec_illegal
);
   generate
      if (BYTE_W != 8) begin : g_bad_width
         $error("opc_predecode: BYTE_W must be 8");
      end
      if (CYC_W < 3) begin : g_bad_cyc
         $error("opc_predecode: cycle field too narrow");
      end
   endgenerate

   logic             take;
   logic             pfx_q;
   logic [LEN_W-1:0] skip_q;
   logic             is_prefix;
   dec_t             cur_dec;
   dec_t             out_q;
   logic             vld_q;

   opc_pdec_table #(
      .BYTE_W  (BYTE_W),
      .PFX_CODE(PFX_CODE),
      .SP_EN   (SP_EN)
   ) u_table (
      .op_byte  (byte_in),
      .pfx_armed(pfx_q),
      .is_prefix(is_prefix),
      .dec      (cur_dec)
   );

   opc_pdec_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_vld (byte_vld),
      .is_prefix(is_prefix),
      .new_len  (cur_dec.len),
      .take     (take),
      .pfx_q    (pfx_q),
      .skip_q   (skip_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         out_q <= '0;
      end else begin
         vld_q <= take;
         if (take) out_q <= cur_dec;
      end
   end

   assign dec_vld     = vld_q;
   assign dec_mode    = out_q.mode;
   assign dec_op      = out_q.op;
   assign dec_len     = out_q.len;
   assign dec_cyc     = out_q.cyc;
   assign dec_bclr    = out_q.bclr;
   assign dec_bit     = out_q.bitn;
   assign dec_illegal = out_q.illegal;
endmodule

// File: rtl/opc_predecode_chk.sv
module opc_predecode_chk #(
   parameter logic [7:0] PFX_CODE = 8'h9E,
   parameter bit         SP_EN    = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       byte_vld,
   input logic [7:0] byte_in,
   input logic       dec_vld,
   input logic [2:0] dec_mode,
   input logic [1:0] dec_len,
   input logic [2:0] dec_cyc,
   input logic       dec_bclr,
   input logic       dec_illegal,
   input logic       pfx_q,
   input logic [1:0] skip_q
);
   AST_VLD_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |-> $past(byte_vld));                                        // R2
   AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (SP_EN && byte_vld && skip_q == 2'd0 && !pfx_q && byte_in == PFX_CODE)
      |=> (!dec_vld && pfx_q));                                             // R6
   AST_SP_NEEDS_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && dec_mode >= 3'd6) |-> ($past(pfx_q) && !pfx_q));          // R6
   AST_OPERAND_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (skip_q != 2'd0) |=> !dec_vld);                                       // R10
   AST_SKIP_MATCHES_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |-> (skip_q == dec_len));                                     // R10
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |=> ($stable(pfx_q) && $stable(skip_q) && !dec_vld));       // R11
   AST_ILLEGAL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && dec_illegal) |-> (dec_len == 2'd0 && dec_cyc == 3'd1 && !dec_bclr)); // R9
   AST_BCLR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && dec_bclr) |-> (dec_mode == 3'd1 && dec_cyc == 3'd4 && dec_len == 2'd1)); // R8
endmodule

bind opc_predecode opc_predecode_chk #(
   .PFX_CODE(PFX_CODE),
   .SP_EN   (SP_EN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .byte_vld   (byte_vld),
   .byte_in    (byte_in),
   .dec_vld    (dec_vld),
   .dec_mode   (dec_mode),
   .dec_len    (dec_len),
   .dec_cyc    (dec_cyc),
   .dec_bclr   (dec_bclr),
   .dec_illegal(dec_illegal),
   .pfx_q      (pfx_q),
   .skip_q     (skip_q)
);

// File: tb/opc_predecode_tb.sv
`timescale 1ns/1ps
module opc_predecode_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       byte_vld = 1'b0;
   logic [7:0] byte_in = 8'h00;
   logic       dec_vld;
   logic [2:0] dec_mode;
   logic [3:0] dec_op;
   logic [1:0] dec_len;
   logic [2:0] dec_cyc;
   logic       dec_bclr;
   logic [2:0] dec_bit;
   logic       dec_illegal;

   int n_vec = 0;
   int n_bad = 0;
   bit m_pfx = 1'b0;
   int m_skip = 0;

   always #2 clk = ~clk;

   opc_predecode u_dut (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
      .dec_vld(dec_vld), .dec_mode(dec_mode), .dec_op(dec_op), .dec_len(dec_len),
      .dec_cyc(dec_cyc), .dec_bclr(dec_bclr), .dec_bit(dec_bit), .dec_illegal(dec_illegal)
   );

   function automatic logic [16:0] ref_dec(input logic [7:0] b, input bit pfx, output string tag);
      logic [3:0] hi = b[7:4];
      logic [3:0] lo = b[3:0];
      logic ill = 1'b0, bc = 1'b0;
      logic [2:0] bn = 3'd0, md = 3'd0, cy = 3'd1;
      logic [1:0] ln = 2'd0;
      if (pfx) begin
         tag = "R6";
         if (hi == 4'hE) begin md = 3'd6; ln = 2'd1; cy = 3'd4; end
         else if (hi == 4'hD) begin md = 3'd7; ln = 2'd2; cy = 3'd5; end
         else begin ill = 1'b1; tag = "R7"; end
      end else if (hi >= 4'hA) begin
         tag = "R3/R4/R5";
         md = 3'(hi - 4'hA);
         case (hi)
            4'hA: begin ln = 2'd1; cy = 3'd2; end
            4'hB: begin ln = 2'd1; cy = 3'd3; end
            4'hC: begin ln = 2'd2; cy = 3'd4; end
            4'hD: begin ln = 2'd2; cy = 3'd4; end
            4'hE: begin ln = 2'd1; cy = 3'd3; end
            default: begin ln = 2'd0; cy = 3'd2; end
         endcase
      end else if (hi == 4'h1 && lo[0]) begin
         tag = "R8";
         bc = 1'b1; bn = 3'((b - 8'h11) / 2); md = 3'd1; ln = 2'd1; cy = 3'd4;
      end else begin
         tag = "R9"; ill = 1'b1;
      end
      return {ill, bc, bn, md, lo, ln, cy};
   endfunction

   task automatic check1(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h @%0t", tag, act, exp, $time);
      end
   endtask

   task automatic put(input logic [7:0] b);
      string tag;
      logic [16:0] e;
      byte_vld = 1'b1;
      byte_in  = b;
      @(negedge clk);
      if (m_skip > 0) begin
         check1("R10 operand byte decoded", 32'(dec_vld), 32'd0);
         m_skip--;
      end else if (!m_pfx && b == 8'h9E) begin
         check1("R6 prefix decoded", 32'(dec_vld), 32'd0);
         m_pfx = 1'b1;
      end else begin
         e = ref_dec(b, m_pfx, tag);
         check1({"R2 vld ", tag}, 32'(dec_vld), 32'd1);
         check1({tag, " fields"},
                32'({dec_illegal, dec_bclr, dec_bit, dec_mode, dec_op, dec_len, dec_cyc}),
                32'(e));
         m_pfx  = 1'b0;
         m_skip = int'(e[4:3]);
      end
   endtask

   task automatic idle(input int n);
      byte_vld = 1'b0;
      byte_in  = 8'h9E;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check1("R11 idle decode", 32'(dec_vld), 32'd0);
      end
   endtask

   task automatic do_reset();
      byte_vld = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check1("R1 vld in reset", 32'(dec_vld), 32'd0);
      rst_n = 1'b1;
      m_pfx = 1'b0;
      m_skip = 0;
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog R2 act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (2) @(negedge clk);
      check1("R1 vld after reset", 32'(dec_vld), 32'd0);
      rst_n = 1'b1;
      // directed: every plain ALU mode with op nibbles 9, B, 4
      put(8'hA9); put(8'h55);
      put(8'hBB); put(8'h10);
      put(8'hC4); put(8'h9E); put(8'hA9);   // R10: operands look like prefix/opcode
      put(8'hD9); put(8'h00); put(8'h00);
      put(8'hEB); put(8'h7F);
      put(8'hF4);
      // prefix forms, with gaps R11
      put(8'h9E); idle(3); put(8'hE9); idle(2); put(8'h04);
      put(8'h9E); put(8'hDB); put(8'h01); put(8'h02);
      // prefix with unsupported nibble, then second prefix R7
      put(8'h9E); put(8'hA9); put(8'h12);
      put(8'h9E); put(8'h9E); put(8'hE4); put(8'h33);
      // bit-clear extremes and even 1x R8 R9
      put(8'h11); put(8'h20);
      put(8'h1F); put(8'h20);
      put(8'h10); put(8'h00); put(8'h37);
      // reset drops an armed prefix R1
      put(8'h9E);
      do_reset();
      put(8'hE5); put(8'h08);
      // random stream
      for (int k = 0; k < 6000; k++) begin
         logic [7:0] b;
         case ($urandom % 8)
            0, 1, 2: b = {4'(4'hA + ($urandom % 6)), 4'($urandom)};
            3:       b = 8'h9E;
            4:       b = {4'h1, 4'($urandom)};
            default: b = 8'($urandom);
         endcase
         put(b);
         if ($urandom % 4 == 0) idle(1 + int'($urandom % 3));
      end
      idle(2);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule